// File: doc/BRIEF.md
# Clock recovery lock monitor

This block supervises a clock recovery loop. It counts the edges of the recovered line clock during a fixed measurement window timed by the local reference clock. It also watches a signal-present indicator that is synchronous to the reference clock. From these two inputs it keeps the loop in one of two states. In the training state, loss-of-lock is raised and the downstream clock multiplexer is told to forward the reference clock. In the locked data-recovery state, loss-of-lock is low and the recovered clock is forwarded.

The recovered-clock edge count crosses into the reference domain as a Gray-coded value through a two-stage synchronizer. At the last reference cycle of each window, the block takes the change in that count since the previous window end and compares it with the nominal count (2^WIN_LOG2). A window is in tolerance when the absolute difference is at most TOL. With the defaults, 10 counts out of 2048 is just under 0.5 %. The analog loop and the glitch-free multiplexer cell sit outside this block.

Top module: `lock_monitor`

## Requirements
- R1: While reset is asserted and after its release, lol is 1 and use_rec_clk is 0 until the lock condition of R4 is met.
- R2: A reference edge that samples sig_present low sets lol to 1 after that edge and clears any partial progress toward lock.
- R3: A window whose recovered edge count differs from 2^WIN_LOG2 by more than TOL sets lol to 1 at that window's end.
- R4: lol falls only at the end of the GOOD_WINS-th consecutive in-tolerance window (default 2) during which sig_present stayed high.
- R5: use_rec_clk is the select for the clock multiplexer: 1 forwards the recovered clock and 0 forwards the reference clock. It is always the inverse of lol.
- R6: Apart from the signal loss of R2, lol changes only on the reference edge that closes a window, once every 2^WIN_LOG2 reference cycles counted from reset release.
- R7: A deviation of about 8 counts per 2048 stays in tolerance, and one of about 13 counts per 2048 does not.
- R8: A stopped recovered clock while sig_present is high gives a zero count and holds or forces training.
- R9: A single out-of-tolerance window between in-tolerance windows restarts the count of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; times the measurement window |
| rec_clk | input | 1 | Recovered line clock under measurement |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sig_present | input | 1 | Line signal present, synchronous to ref_clk |
| lol | output | 1 | Loss-of-lock flag, high in training |
| use_rec_clk | output | 1 | Clock select: 1 recovered, 0 reference |

## Verification
The assertions assume that sig_present is already synchronous to ref_clk. They also assume that reset is released to both clock domains at the same instant, so the checker's own cycle counter lines up with the window boundaries. The bench changes sig_present only between reference edges. It changes the recovered clock period only on window boundaries, and it picks test periods at least two counts away from the tolerance limit. Synchronizer latency and phase therefore cannot move any window decision to the other side of the limit.

// File: rtl/lock_monitor.sv
`timescale 1ns/1ps
module lock_monitor #(
  parameter int WIN_LOG2  = 11,
  parameter int TOL       = 10,
  parameter int GOOD_WINS = 2
) (
  input  logic ref_clk,
  input  logic rec_clk,
  input  logic rst_n,
  input  logic sig_present,
  output logic lol,
  output logic use_rec_clk
);
  localparam int CW = WIN_LOG2 + 3;
  localparam int GW = $clog2(GOOD_WINS + 1);
  localparam logic [CW-1:0] NOM = CW'(1) << WIN_LOG2;

  function automatic logic [CW-1:0] gray2bin(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [CW-1:0] rec_bin, rec_gray, rec_nxt;
  assign rec_nxt = rec_bin + 1'b1;

  always_ff @(posedge rec_clk or negedge rst_n)
    if (!rst_n) begin
      rec_bin  <= '0;
      rec_gray <= '0;
    end else begin
      rec_bin  <= rec_nxt;
      rec_gray <= rec_nxt ^ (rec_nxt >> 1);
    end

  logic [CW-1:0] sync_a, sync_b, prev_bin, now_bin, delta, err;
  logic [WIN_LOG2-1:0] win_cnt;
  logic [GW-1:0] good_cnt;
  logic win_end, in_tol;

  assign now_bin = gray2bin(sync_b);
  assign delta   = now_bin - prev_bin;
  assign err     = (delta >= NOM) ? delta - NOM : NOM - delta;
  assign in_tol  = err <= CW'(TOL);
  assign win_end = &win_cnt;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      sync_a   <= '0;
      sync_b   <= '0;
      prev_bin <= '0;
      win_cnt  <= '0;
      good_cnt <= '0;
      lol      <= 1'b1;
    end else begin
      sync_a  <= rec_gray;
      sync_b  <= sync_a;
      win_cnt <= win_cnt + 1'b1;
      if (win_end) prev_bin <= now_bin;
      if (!sig_present) begin
        lol      <= 1'b1;
        good_cnt <= '0;
      end else if (win_end) begin
        if (!in_tol) begin
          lol      <= 1'b1;
          good_cnt <= '0;
        end else if (good_cnt >= GW'(GOOD_WINS - 1)) begin
          lol      <= 1'b0;
          good_cnt <= GW'(GOOD_WINS);
        end else begin
          good_cnt <= good_cnt + 1'b1;
        end
      end
    end

  assign use_rec_clk = ~lol;
endmodule

// File: rtl/lock_monitor_chk.sv
`timescale 1ns/1ps
module lock_monitor_chk #(
  parameter int WIN_LOG2 = 11
) (
  input logic ref_clk,
  input logic rst_n,
  input logic sig_present,
  input logic lol,
  input logic use_rec_clk
);
  logic [WIN_LOG2-1:0] phase;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;

  p_nosig_forces_lol_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !sig_present |=> lol);

  p_lock_needs_signal_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !lol |-> $past(sig_present));

  p_lock_at_window_end_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(lol) |-> phase == '0);

  p_select_inverse_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    use_rec_clk != lol);

  p_hold_mid_window_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (phase != '0 && $past(sig_present)) |-> $stable(lol));
endmodule

bind lock_monitor lock_monitor_chk #(.WIN_LOG2(WIN_LOG2)) u_chk (
  .ref_clk(ref_clk),
  .rst_n(rst_n),
  .sig_present(sig_present),
  .lol(lol),
  .use_rec_clk(use_rec_clk)
);

// File: tb/lock_monitor_bench.sv
`timescale 1ns/1ps
module lock_monitor_bench;
  localparam int WIN = 2048;
  logic ref_clk = 0, rec_clk = 0, rst_n = 0, sig_present = 0;
  logic lol, use_rec_clk;
  int rec_per = 8000;
  int tests = 0, fails = 0;
  int phase = 0, good = 0;
  bit exp_lol = 1;
  string tag = "R1";

  always #4 ref_clk = ~ref_clk;

  initial begin
    #1.3;
    forever begin
      if (rec_per == 0) #1;
      else begin
        #(rec_per / 2000.0);
        rec_clk = ~rec_clk;
      end
    end
  end

  lock_monitor u_lock_monitor (
    .ref_clk(ref_clk), .rec_clk(rec_clk), .rst_n(rst_n),
    .sig_present(sig_present), .lol(lol), .use_rec_clk(use_rec_clk)
  );

  function automatic bit tol_ok(int per);
    real n;
    if (per == 0) return 0;
    n = 2048.0 * 8000.0 / per;
    return (n - 2048.0 <= 10.0) && (2048.0 - n <= 10.0);
  endfunction

  task automatic check();
    tests++;
    if (lol !== exp_lol || use_rec_clk !== !exp_lol) begin
      fails++;
      $display("FAIL %s: lol=%0b use_rec_clk=%0b expected lol=%0b use_rec_clk=%0b",
               tag, lol, use_rec_clk, exp_lol, !exp_lol);
    end
  endtask

  task automatic step(bit sp, int per);
    if (!sp) begin
      exp_lol = 1;
      good = 0;
    end else if (phase == WIN - 1) begin
      if (!tol_ok(per)) begin
        exp_lol = 1;
        good = 0;
      end else if (good >= 1) begin
        exp_lol = 0;
        good = 2;
      end else good++;
    end
    phase = (phase + 1) % WIN;
  endtask

  task automatic run(int n, int per, bit sp, string t);
    for (int k = 0; k < n; k++) begin
      @(negedge ref_clk);
      check();
      tag = t;
      rec_per = per;
      sig_present = sp;
      step(sp, per);
    end
  endtask

  initial begin
    #(400_000 * 8);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    sig_present = 1;
    repeat (3) @(negedge ref_clk);
    check();
    @(negedge ref_clk);
    check();
    rst_n = 1;
    step(1, 8000);
    run(2 * WIN, 8000, 1, "R4");
    run(WIN, 8000, 1, "R5");
    run(1000, 8000, 1, "R5");
    run(50, 8000, 0, "R2");
    run(998, 8000, 1, "R6");
    run(2 * WIN, 8000, 1, "R4");
    run(WIN, 8100, 1, "R3");
    run(WIN, 8000, 1, "R4");
    run(WIN, 8100, 1, "R9");
    run(WIN, 8000, 1, "R9");
    run(WIN, 8000, 1, "R9");
    run(2 * WIN, 8030, 1, "R7");
    run(WIN, 7950, 1, "R7");
    run(2 * WIN, 8000, 1, "R4");
    run(2 * WIN, 0, 1, "R8");
    run(3 * WIN, 8000, 1, "R8");
    @(negedge ref_clk);
    check();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule